// File: doc/BRIEF.md
# BT.656 Byte Stream Formatter

The formatter turns decoded 4:2:2 video into the 8-bit, double-rate byte stream of a digital video port. On every byte clock the caller presents one luma sample and one chroma sample. The block keeps its own horizontal byte position within the line. From that position it decides whether the byte slot is active picture, blanking, or part of a timing reference code. Line-level vertical-valid and field flags set the vertical state of each line.

Two output styles are selectable at run time. With embedded sync, each line opens with an end-of-active-video code and each active region is preceded by a start-of-active-video code. Each code is four bytes. With separate sync, those slots carry ordinary blanking data, and an active-pixel qualifier marks the picture bytes instead. Blanking normally carries the neutral fill pattern. An option lets luma samples pass through into the luma slots of blanking. The line length follows a 525-line or 625-line select, and that select is taken at the start of each line.

Top module: `bt656_byte_formatter`

## Requirements
- R1: While reset is held, and on the first clock after it, the outputs are `byte_o`=0x00, `pix_valid`=0 and `line_head`=0.
- R2: A line lasts 1716 byte clocks when `sel_625` is 0 and 1728 when it is 1. The select is sampled only at line position 0, so a change in mid-line does not alter the current line's length.
- R3: Position 0 is the first byte of a line. Positions 0..3 hold the end-of-active code. Positions B-4..B-1 hold the start-of-active code. Positions B..B+1439 are active, with B=276 for 525-line and B=288 for 625-line operation.
- R4: In embedded mode (`embed_en`=1), each code is 0xFF, 0x00, 0x00, XY. XY is laid out as bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R5: V is the inverse of `vvalid_in` and F equals `field_in`. Both are sampled at position 0 and then held for the rest of the line.
- R6: On an active byte of a line with vertical-valid set, an even offset from B carries `chroma_in` and an odd offset carries `luma_in`.
- R7: Every data byte taken from `luma_in` or `chroma_in` has 0x00 replaced by 0x01 and 0xFF replaced by 0xFE.
- R8: A blanking byte carries 0x80 at even line positions and 0x10 at odd line positions.
- R9: With `luma_pass`=1, the odd blanking positions carry the clipped `luma_in` instead of 0x10. The even positions stay at 0x80.
- R10: In separate mode (`embed_en`=0), the code positions carry blanking data as in R8/R9.
- R11: `pix_valid` is 1 exactly on active bytes of lines whose sampled vertical-valid is 1.
- R12: On a line with vertical-valid 0, the active region carries blanking data. The codes are still sent in embedded mode.
- R13: Each output byte appears one clock after the inputs at its position are presented. `line_head` is 1 with the byte of position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| embed_en | input | 1 | 1 selects embedded reference codes, 0 selects separate-sync output |
| luma_pass | input | 1 | 1 passes luma through into blanking |
| sel_625 | input | 1 | 0 selects 525-line line length, 1 selects 625-line line length |
| vvalid_in | input | 1 | Vertical active-line flag |
| field_in | input | 1 | Field flag |
| luma_in | input | 8 | Luma sample for the current byte slot |
| chroma_in | input | 8 | Chroma sample for the current byte slot (Cb/Cr alternation is up to the caller) |
| byte_o | output | 8 | Multiplexed output byte |
| pix_valid | output | 1 | Active-pixel qualifier |
| line_head | output | 1 | Marks the first byte of each line |

## Verification
The checks assume that all inputs are synchronous to the byte clock. They also assume that the caller holds the mode inputs steady across the stretches being compared, so the pattern seen on a line-head byte can be tied to the mode of the previous clock. The stimulus changes inputs only on the falling edge. It keeps `embed_en` and `luma_pass` fixed for a whole line. Only the line-length select and the vertical flags are disturbed in mid-line, which checks that they are ignored there. The data ramps run through all 256 values within an active line, so the clipped values 0x00 and 0xFF reach both the luma slots and the chroma slots.

// File: rtl/bt656f_pkg.sv
package bt656f_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_LEN = 4;

    localparam logic [DATA_W-1:0] FILL_CHROMA = 8'h80;
    localparam logic [DATA_W-1:0] FILL_LUMA   = 8'h10;
    localparam logic [DATA_W-1:0] CODE_LEAD   = 8'hFF;
    localparam logic [DATA_W-1:0] CODE_PAD    = 8'h00;

    typedef enum logic [1:0] {
        RG_EAV,
        RG_BLANK,
        RG_SAV,
        RG_ACT
    } region_e;

    // classification of one byte slot of the line
    typedef struct packed {
        region_e    rg;
        logic [1:0] sub;   // byte index inside a reference code
        logic       odd;   // odd line position = luma slot
        logic       head;  // position 0
    } slot_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              head;
    } out_t;

    // keep data bytes away from the reserved code values
    function automatic logic [DATA_W-1:0] clip_sample(input logic [DATA_W-1:0] s);
        if (s == 8'h00) return 8'h01;
        if (s == 8'hFF) return 8'hFE;
        return s;
    endfunction

    // fourth byte of a reference code with its protection bits
    function automatic logic [DATA_W-1:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/bt656f_timing.sv
module bt656f_timing
    import bt656f_pkg::*;
#(
    parameter int ACT_BYTES = 1440,
    parameter int LINE_525  = 1716,
    parameter int LINE_625  = 1728,
    parameter int PW        = $clog2(LINE_625 + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_625,
    output slot_t slot
);

    localparam logic [PW-1:0] LAST_525  = PW'(LINE_525 - 1);
    localparam logic [PW-1:0] LAST_625  = PW'(LINE_625 - 1);
    localparam logic [PW-1:0] START_525 = PW'(LINE_525 - ACT_BYTES);
    localparam logic [PW-1:0] START_625 = PW'(LINE_625 - ACT_BYTES);
    localparam logic [PW-1:0] CODE_SPAN = PW'(CODE_LEN);

    logic [PW-1:0] hpos;
    logic          len_q;
    logic          at_head;
    logic          use_625;
    logic [PW-1:0] last_pos;
    logic [PW-1:0] act_start;
    logic [PW-1:0] sav_start;
    logic [PW-1:0] sav_off;

    assign at_head   = (hpos == '0);
    assign use_625   = at_head ? sel_625 : len_q;
    assign last_pos  = use_625 ? LAST_625 : LAST_525;
    assign act_start = use_625 ? START_625 : START_525;
    assign sav_start = act_start - CODE_SPAN;
    assign sav_off   = hpos - sav_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos  <= '0;
            len_q <= 1'b0;
        end else begin
            if (at_head) len_q <= sel_625;
            hpos <= (hpos == last_pos) ? '0 : hpos + 1'b1;
        end
    end

    always_comb begin
        slot.odd  = hpos[0];
        slot.head = at_head;
        slot.sub  = 2'b00;
        if (hpos < CODE_SPAN) begin
            slot.rg  = RG_EAV;
            slot.sub = hpos[1:0];
        end else if (hpos >= act_start) begin
            slot.rg  = RG_ACT;
        end else if (hpos >= sav_start) begin
            slot.rg  = RG_SAV;
            slot.sub = sav_off[1:0];
        end else begin
            slot.rg  = RG_BLANK;
        end
    end

endmodule

// File: rtl/bt656f_fieldflags.sv
module bt656f_fieldflags (
    input  logic clk,
    input  logic rst,
    input  logic head,
    input  logic vvalid_in,
    input  logic field_in,
    output logic v_bit,
    output logic f_bit
);

    logic vvalid_q;
    logic field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vvalid_q <= 1'b0;
            field_q  <= 1'b0;
        end else if (head) begin
            vvalid_q <= vvalid_in;
            field_q  <= field_in;
        end
    end

    // position 0 uses the live flags, the rest of the line the held ones
    assign v_bit = head ? ~vvalid_in : ~vvalid_q;
    assign f_bit = head ? field_in : field_q;

endmodule

// File: rtl/bt656f_bytemux.sv
module bt656f_bytemux
    import bt656f_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_t             slot,
    input  logic              embed_en,
    input  logic              luma_pass,
    input  logic              v_bit,
    input  logic              f_bit,
    input  logic [DATA_W-1:0] luma_in,
    input  logic [DATA_W-1:0] chroma_in,
    output out_t              out_q
);

    out_t nxt;
    logic code_slot;

    assign code_slot = (slot.rg == RG_EAV) || (slot.rg == RG_SAV);

    always_comb begin
        nxt.data  = FILL_CHROMA;
        nxt.valid = 1'b0;
        nxt.head  = slot.head;
        if (code_slot && embed_en) begin
            case (slot.sub)
                2'd0:    nxt.data = CODE_LEAD;
                2'd3:    nxt.data = xy_word(f_bit, v_bit, slot.rg == RG_EAV);
                default: nxt.data = CODE_PAD;
            endcase
        end else if (slot.rg == RG_ACT && !v_bit) begin
            nxt.data  = slot.odd ? clip_sample(luma_in) : clip_sample(chroma_in);
            nxt.valid = 1'b1;
        end else if (slot.odd) begin
            nxt.data  = luma_pass ? clip_sample(luma_in) : FILL_LUMA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

endmodule

// File: rtl/bt656_byte_formatter.sv
module bt656_byte_formatter
    import bt656f_pkg::*;
#(
    parameter int ACT_BYTES = 1440,
    parameter int LINE_525  = 1716,
    parameter int LINE_625  = 1728
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              embed_en,
    input  logic              luma_pass,
    input  logic              sel_625,
    input  logic              vvalid_in,
    input  logic              field_in,
    input  logic [DATA_W-1:0] luma_in,
    input  logic [DATA_W-1:0] chroma_in,
    output logic [DATA_W-1:0] byte_o,
    output logic              pix_valid,
    output logic              line_head
);

    slot_t slot;
    logic  v_bit;
    logic  f_bit;
    out_t  out_q;

    bt656f_timing #(
        .ACT_BYTES (ACT_BYTES),
        .LINE_525  (LINE_525),
        .LINE_625  (LINE_625)
    ) u_timing (
        .clk     (clk),
        .rst     (rst),
        .sel_625 (sel_625),
        .slot    (slot)
    );

    bt656f_fieldflags u_flags (
        .clk       (clk),
        .rst       (rst),
        .head      (slot.head),
        .vvalid_in (vvalid_in),
        .field_in  (field_in),
        .v_bit     (v_bit),
        .f_bit     (f_bit)
    );

    bt656f_bytemux u_mux (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .embed_en  (embed_en),
        .luma_pass (luma_pass),
        .v_bit     (v_bit),
        .f_bit     (f_bit),
        .luma_in   (luma_in),
        .chroma_in (chroma_in),
        .out_q     (out_q)
    );

    assign byte_o    = out_q.data;
    assign pix_valid = out_q.valid;
    assign line_head = out_q.head;

endmodule

// File: rtl/bt656f_checker.sv
module bt656f_checker #(
    parameter int LINE_525 = 1716,
    parameter int LINE_625 = 1728
) (
    input logic       clk,
    input logic       rst,
    input logic       embed_en,
    input logic [7:0] byte_o,
    input logic       pix_valid,
    input logic       line_head
);

    localparam int CW = $clog2(LINE_625 + 2);

    logic          started;
    logic          mode_q;
    logic          seen_head;
    logic [CW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            started   <= 1'b0;
            mode_q    <= 1'b0;
            seen_head <= 1'b0;
            gap       <= '0;
        end else begin
            started <= 1'b1;
            mode_q  <= embed_en;
            if (line_head) begin
                seen_head <= 1'b1;
                gap       <= CW'(1);
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (byte_o == 8'h00 && !pix_valid && !line_head));

    p_line_len_r2: assert property (@(posedge clk) disable iff (rst)
        (line_head && seen_head) |-> (gap == CW'(LINE_525) || gap == CW'(LINE_625)));

    p_head_not_active_r3: assert property (@(posedge clk) disable iff (rst)
        line_head |-> !pix_valid);

    p_head_lead_r4: assert property (@(posedge clk) disable iff (rst)
        (started && mode_q && line_head) |-> byte_o == 8'hFF);

    p_active_clipped_r7: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (byte_o != 8'h00 && byte_o != 8'hFF));

    p_sep_no_codes_r10: assert property (@(posedge clk) disable iff (rst)
        (started && !mode_q) |-> (byte_o != 8'h00 && byte_o != 8'hFF));

endmodule

bind bt656_byte_formatter bt656f_checker #(
    .LINE_525 (LINE_525),
    .LINE_625 (LINE_625)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .embed_en  (embed_en),
    .byte_o    (byte_o),
    .pix_valid (pix_valid),
    .line_head (line_head)
);

// File: tb/bt656_byte_formatter_test.sv
`timescale 1ns/1ps
module bt656_byte_formatter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       embed_en = 1'b1;
    logic       luma_pass = 1'b0;
    logic       sel_625 = 1'b0;
    logic       vvalid_in = 1'b1;
    logic       field_in = 1'b0;
    logic [7:0] luma_in = 8'h00;
    logic [7:0] chroma_in = 8'h00;
    logic [7:0] byte_o;
    logic       pix_valid;
    logic       line_head;

    always #2.5 clk = ~clk;

    bt656_byte_formatter uut (
        .clk       (clk),
        .rst       (rst),
        .embed_en  (embed_en),
        .luma_pass (luma_pass),
        .sel_625   (sel_625),
        .vvalid_in (vvalid_in),
        .field_in  (field_in),
        .luma_in   (luma_in),
        .chroma_in (chroma_in),
        .byte_o    (byte_o),
        .pix_valid (pix_valid),
        .line_head (line_head)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    int    bp = 0;
    bit    m625, mvv, mfld;
    int    kseed = 0;
    int    e_byte;
    bit    e_valid, e_head;
    string e_tag;

    // config: embed, pass, l625, vvalid, field, seed
    localparam logic [12:0] TBL [8] = '{
        {5'b10010, 8'd0},
        {5'b10111, 8'd17},
        {5'b11011, 8'd40},
        {5'b10000, 8'd3},
        {5'b00010, 8'd9},
        {5'b01110, 8'd77},
        {5'b00101, 8'd5},
        {5'b11101, 8'd250}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (pos %0d)", tag, act, exp, bp);
        end
    endtask

    function automatic int clipv(input int s);
        if (s == 0) return 1;
        if (s == 255) return 254;
        return s;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    // one byte clock: drive at the falling edge, check one clock later
    task automatic cycle_once();
        int  b0;
        bit  code_pos, h;
        int  sub, xy, v;
        luma_in   = 8'(((bp >> 1) * 5 + kseed) & 255);
        chroma_in = 8'(((bp >> 1) * 3 + kseed + 11) & 255);
        if (bp == 0) begin
            m625 = sel_625;
            mvv  = vvalid_in;
            mfld = field_in;
        end
        b0 = m625 ? 288 : 276;
        code_pos = (bp < 4) || (bp >= b0 - 4 && bp < b0);
        e_valid = 0;
        e_head  = (bp == 0);
        if (code_pos && embed_en) begin
            h   = (bp < 4);
            sub = h ? bp : bp - (b0 - 4);
            v   = !mvv;
            xy  = {1'b1, mfld, v[0], h, v[0] ^ h, mfld ^ h, mfld ^ v[0], mfld ^ v[0] ^ h};
            e_byte = (sub == 0) ? 255 : (sub == 3) ? xy : 0;
            e_tag  = "R3 R4 R5";
        end else if (bp >= b0 && mvv) begin
            e_byte  = bp[0] ? clipv(int'(luma_in)) : clipv(int'(chroma_in));
            e_valid = 1;
            e_tag   = "R6 R7";
        end else begin
            if (bp[0]) e_byte = luma_pass ? clipv(int'(luma_in)) : 8'h10;
            else       e_byte = 8'h80;
            if (code_pos)      e_tag = "R10";
            else if (bp >= b0) e_tag = "R12";
            else if (luma_pass) e_tag = "R9";
            else               e_tag = "R8";
        end
        @(posedge clk);
        @(negedge clk);
        chk(int'(byte_o) == e_byte, e_tag, int'(byte_o), e_byte);
        chk(pix_valid == e_valid, "R11", int'(pix_valid), int'(e_valid));
        chk(line_head == e_head, "R2 R13", int'(line_head), int'(e_head));
        bp = (bp == (m625 ? 1727 : 1715)) ? 0 : bp + 1;
    endtask

    task automatic apply(input logic [12:0] e);
        embed_en  = e[12];
        luma_pass = e[11];
        sel_625   = e[10];
        vvalid_in = e[9];
        field_in  = e[8];
        kseed     = int'(e[7:0]);
    endtask

    task automatic run_line(output int n);
        n = 0;
        do begin
            cycle_once();
            n++;
        end while (bp != 0);
    endtask

    task automatic reset_check();
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
            chk(byte_o == 8'h00 && !pix_valid && !line_head, "R1",
                {pix_valid, line_head, byte_o}, 0);
        end
    endtask

    initial begin
        int n;
        @(negedge clk);
        reset_check();
        rst = 1'b0;
        bp  = 0;

        // table walk: one full line per entry
        foreach (TBL[i]) begin
            apply(TBL[i]);
            run_line(n);
            chk(n == (TBL[i][10] ? 1728 : 1716), "R2", n, TBL[i][10] ? 1728 : 1716);
        end

        // mid-line changes of length select and vertical flags are ignored
        apply({5'b10010, 8'd31});
        n = 0;
        do begin
            if (n == 600) begin
                sel_625   = 1'b1;
                vvalid_in = 1'b0;
                field_in  = 1'b1;
            end
            cycle_once();
            n++;
        end while (bp != 0);
        chk(n == 1716, "R2 R5", n, 1716);

        // line after that picks up the new settings
        run_line(n);
        chk(n == 1728, "R2", n, 1728);

        // reset in mid-line
        apply({5'b10011, 8'd60});
        repeat (300) cycle_once();
        rst = 1'b1;
        reset_check();
        rst = 1'b0;
        bp  = 0;
        run_line(n);
        chk(n == 1716, "R1 R2", n, 1716);

        summary();
        $finish;
    end

endmodule